// File: doc/BRIEF.md
# SD Multi-Block Data Phase Sequencer

This block runs the data phase of multi-block SD/MMC reads and writes. It sits between an internal word buffer and the card-side serialiser. It moves one buffer word per card clock and counts words into blocks. It also counts blocks down when counting is enabled. It gates the card clock whenever the buffer cannot keep up, and it releases the clock by itself once the buffer recovers. The stop command is issued automatically after the last counted block. When a stop command finishes, the block waits for the card to release its busy indication on DAT0.

Software drives a small control port:
- `start` with a block count, a count enable and a direction.
- a stop-at-gap request.
- a continue request.
- an abort.

A gap request pauses the transfer cleanly between two blocks and raises transfer-complete. A continue request resumes from the next block. An abort issues a stop command at once and also halts the buffer-side traffic in the same cycle.

The controller is a five-state machine:
- `S_IDLE`: waits for `start`.
- `S_XFER`: moves words.
- `S_PAUSE`: parked at a block gap.
- `S_STOP`: one cycle, issuing the stop command with the clock forced on.
- `S_BUSY`: waits for DAT0 to return high.

The transitions are:
- IDLE→XFER on `start`.
- XFER→PAUSE at a block end with a gap request pending.
- XFER→STOP on the last counted block or on an abort.
- PAUSE→XFER on `cont_req`.
- PAUSE→STOP on an abort.
- STOP→BUSY always.
- BUSY→IDLE when DAT0 is high.

Top module: `sdseq_xfer_ctrl`

## Requirements
- R1: After reset the block is idle: `card_clk_en`, `buf_stb`, `stop_cmd`, `clk_off`, `xfer_done`, `rd_tmo` and `busy_end_irq` are all 0.
- R2: With `cnt_en`=1 at `start`, exactly N×BLK_WORDS buffer strobes occur, then one `stop_cmd` pulse. N is `blk_cnt`, and a `blk_cnt` of 0 means 2^CNT_W blocks.
- R3: During a read (`dir_rd`=1) with `buf_full`=1, or a write with `buf_empty`=1, `card_clk_en`=0, `clk_off`=1 and `buf_stb`=0. The clock resumes by itself when the flag clears.
- R4: A one-cycle `gap_req` given at any point inside a block pauses the transfer at the end of that block: no further strobes, and `xfer_done`=1.
- R5: `cont_req` while paused resumes the transfer, and the total strobe count still equals N×BLK_WORDS.
- R6: With `cnt_en`=0 the transfer runs past any block count with no `stop_cmd` until an abort.
- R7: `abort_req` during a transfer or a pause suppresses `buf_stb` in that cycle and after it, and gives exactly one `stop_cmd` in the next cycle.
- R8: `card_clk_en`=1 in every cycle in which `stop_cmd`=1, even if the buffer flag would gate the clock.
- R9: `dat0_busy` is the inverse of `dat0` at all times. After a stop command, the first cycle with `dat0`=1 gives one `busy_end_irq` pulse, and then `xfer_done`=1 and the block is idle.
- R10: During a read with the clock running and `card_vld`=0 for TMO_CYC consecutive cycles, `rd_tmo` becomes 1 and stays 1 until the next `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted in idle) |
| blk_cnt | input | CNT_W | Block count; 0 means 2^CNT_W |
| cnt_en | input | 1 | Enable block counting and automatic stop |
| dir_rd | input | 1 | 1 = read (card to buffer), 0 = write |
| gap_req | input | 1 | Pause at next block gap |
| cont_req | input | 1 | Resume from a gap pause |
| abort_req | input | 1 | Issue stop command and halt buffer traffic |
| buf_full | input | 1 | Receive buffer full |
| buf_empty | input | 1 | Transmit buffer empty |
| card_vld | input | 1 | Read word present on the card side |
| dat0 | input | 1 | Card DAT0 level (low = busy) |
| card_clk_en | output | 1 | Card clock enable |
| buf_stb | output | 1 | One buffer word moved this cycle |
| stop_cmd | output | 1 | Stop command issue pulse |
| clk_off | output | 1 | Clock gated by buffer state |
| xfer_done | output | 1 | Transfer-complete status |
| dat0_busy | output | 1 | Live DAT0 busy status |
| busy_end_irq | output | 1 | Busy released after stop command |
| rd_tmo | output | 1 | Read data timeout flag |

## Verification
The assertions assume that software raises `start` only while the block is idle. They assume `cont_req` is raised only while the block is paused. They assume the buffer flag for the active direction is the only thing that gates the clock. The bench keeps within these assumptions: it waits for `xfer_done` and the idle state before each new `start`, and it issues continues only after it has seen the pause. The buffer flags and `card_vld` are randomised with a fixed seed. Gap, abort and timeout events are placed by directed sequences at chosen points inside a block.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_XFER  = 3'd1,
        S_PAUSE = 3'd2,
        S_STOP  = 3'd3,
        S_BUSY  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sdseq_clk_gate.sv
module sdseq_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_xfer,
    input  logic in_stop,
    input  logic dir_rd,
    input  logic buf_full,
    input  logic buf_empty,
    output logic gate_ok,
    output logic clk_en,
    output logic clk_off
);
    // Buffer can take or give a word in the current direction
    assign gate_ok = dir_rd ? !buf_full : !buf_empty;
    // A pending stop command always gets a running clock
    assign clk_en  = (in_xfer && gate_ok) || in_stop;
    assign clk_off = in_xfer && !gate_ok;

    assert_gated_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && (dir_rd ? buf_full : buf_empty)) |-> !clk_en);
    assert_stop_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> (clk_en && !clk_off));
endmodule

// File: rtl/sdseq_blk_count.sv
module sdseq_blk_count #(
    parameter int CNT_W     = 16,
    parameter int BLK_WORDS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_en,
    input  logic             stb,
    output logic             blk_end,
    output logic             last_blk
);
    localparam int WI_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [WI_W-1:0] LAST_WI = WI_W'(BLK_WORDS - 1);
    localparam logic [CNT_W:0]  MAX_BLK = {1'b1, {CNT_W{1'b0}}};

    logic [WI_W-1:0] word_idx;
    logic [CNT_W:0]  left;
    logic            en_q;

    assign blk_end  = stb && (word_idx == LAST_WI);
    assign last_blk = en_q && (left == {{CNT_W{1'b0}}, 1'b1});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx <= '0;
            left     <= '0;
            en_q     <= 1'b0;
        end else if (load) begin
            word_idx <= '0;
            left     <= (cnt_val == '0) ? MAX_BLK : {1'b0, cnt_val};
            en_q     <= cnt_en;
        end else if (stb) begin
            word_idx <= blk_end ? '0 : word_idx + 1'b1;
            if (blk_end && en_q)
                left <= left - 1'b1;
        end
    end

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && en_q) |-> (left != '0));
endmodule

// File: rtl/sdseq_rd_timeout.sv
module sdseq_rd_timeout #(
    parameter int TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic watch,
    output logic tmo_flag
);
    localparam int TC_W = $clog2(TMO_CYC + 1);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TMO_CYC - 1);

    logic [TC_W-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            tmo_flag <= 1'b0;
        end else if (clr) begin
            idle_cnt <= '0;
            tmo_flag <= 1'b0;
        end else if (watch) begin
            if (idle_cnt == TC_LAST)
                tmo_flag <= 1'b1;
            else
                idle_cnt <= idle_cnt + 1'b1;
        end else begin
            idle_cnt <= '0;
        end
    end

    assert_tmo_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(watch));
endmodule

// File: rtl/sdseq_xfer_ctrl.sv
module sdseq_xfer_ctrl
    import sdseq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BLK_WORDS = 128,
    parameter int TMO_CYC   = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             cnt_en,
    input  logic             dir_rd,
    input  logic             gap_req,
    input  logic             cont_req,
    input  logic             abort_req,
    input  logic             buf_full,
    input  logic             buf_empty,
    input  logic             card_vld,
    input  logic             dat0,
    output logic             card_clk_en,
    output logic             buf_stb,
    output logic             stop_cmd,
    output logic             clk_off,
    output logic             xfer_done,
    output logic             dat0_busy,
    output logic             busy_end_irq,
    output logic             rd_tmo
);
    seq_state_t st, st_nx;
    logic dir_q, gap_pend, done_q;
    logic gate_ok, blk_end, last_blk;
    logic go, resume, in_xfer, in_stop, tmo_watch;

    assign in_xfer = (st == S_XFER);
    assign in_stop = (st == S_STOP);
    assign go      = (st == S_IDLE) && start;
    assign resume  = (st == S_PAUSE) && cont_req && !abort_req;

    sdseq_clk_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_xfer  (in_xfer),
        .in_stop  (in_stop),
        .dir_rd   (dir_q),
        .buf_full (buf_full),
        .buf_empty(buf_empty),
        .gate_ok  (gate_ok),
        .clk_en   (card_clk_en),
        .clk_off  (clk_off)
    );

    sdseq_blk_count #(.CNT_W(CNT_W), .BLK_WORDS(BLK_WORDS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .cnt_val (blk_cnt),
        .cnt_en  (cnt_en),
        .stb     (buf_stb),
        .blk_end (blk_end),
        .last_blk(last_blk)
    );

    assign tmo_watch = in_xfer && dir_q && gate_ok && !card_vld;

    sdseq_rd_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .watch   (tmo_watch),
        .tmo_flag(rd_tmo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_XFER;
            S_XFER: begin
                if (abort_req)                          st_nx = S_STOP;
                else if (blk_end && last_blk)           st_nx = S_STOP;
                else if (blk_end && (gap_pend || gap_req)) st_nx = S_PAUSE;
            end
            S_PAUSE: begin
                if (abort_req)     st_nx = S_STOP;
                else if (cont_req) st_nx = S_XFER;
            end
            S_STOP:  st_nx = S_BUSY;
            S_BUSY:  if (dat0) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        buf_stb      = 1'b0;
        stop_cmd     = 1'b0;
        busy_end_irq = 1'b0;
        unique case (st)
            S_XFER:  buf_stb = gate_ok && !abort_req && (dir_q ? card_vld : 1'b1);
            S_STOP:  stop_cmd = 1'b1;
            S_BUSY:  busy_end_irq = dat0;
            default: ;
        endcase
    end

    assign dat0_busy = !dat0;
    assign xfer_done = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            gap_pend <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (go) dir_q <= dir_rd;
            if (go || st_nx != S_XFER)  gap_pend <= 1'b0;
            else if (in_xfer && gap_req) gap_pend <= 1'b1;
            if (go || resume)
                done_q <= 1'b0;
            else if ((in_xfer && st_nx == S_PAUSE) || (st == S_BUSY && dat0))
                done_q <= 1'b1;
        end
    end

    assert_pause_at_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && st_nx == S_PAUSE) |-> blk_end);
    assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && (st == S_XFER || st == S_PAUSE)) |=> (stop_cmd && !buf_stb));
    assert_abort_no_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !buf_stb);
    assert_busy_end_dat0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_end_irq |=> (xfer_done && st == S_IDLE));
    assert_stb_buffer_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_stb |-> (dir_q ? !buf_full : !buf_empty));
endmodule

// File: tb/sdseq_xfer_ctrl_bench.sv
module sdseq_xfer_ctrl_bench;
    localparam int CW  = 5;
    localparam int BW  = 4;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, cnt_en = 0, dir_rd = 0, gap_req = 0, cont_req = 0, abort_req = 0;
    logic buf_full = 0, buf_empty = 0, card_vld = 0, dat0 = 0;
    logic [CW-1:0] blk_cnt = '0;
    logic card_clk_en, buf_stb, stop_cmd, clk_off, xfer_done, dat0_busy, busy_end_irq, rd_tmo;

    int checks = 0, fails = 0;
    int n_stb = 0, n_stop = 0, n_bend = 0, n_stop_noclk = 0, n_busy_bad = 0;

    always #2.5 clk = ~clk;

    sdseq_xfer_ctrl #(.CNT_W(CW), .BLK_WORDS(BW), .TMO_CYC(TMO)) u_sdseq_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_cnt(blk_cnt), .cnt_en(cnt_en),
        .dir_rd(dir_rd), .gap_req(gap_req), .cont_req(cont_req), .abort_req(abort_req),
        .buf_full(buf_full), .buf_empty(buf_empty), .card_vld(card_vld), .dat0(dat0),
        .card_clk_en(card_clk_en), .buf_stb(buf_stb), .stop_cmd(stop_cmd), .clk_off(clk_off),
        .xfer_done(xfer_done), .dat0_busy(dat0_busy), .busy_end_irq(busy_end_irq), .rd_tmo(rd_tmo)
    );

    // Mid-cycle monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_stb) n_stb++;
            if (stop_cmd) n_stop++;
            if (busy_end_irq) n_bend++;
            if (stop_cmd && !card_clk_en) n_stop_noclk++;
            if (dat0_busy !== !dat0) n_busy_bad++;
        end
    end

    function automatic int exp_words(input int n);
        return ((n == 0) ? (1 << CW) : n) * BW;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic kick(input int n, input bit en, input bit rd);
        blk_cnt = CW'(n); cnt_en = en; dir_rd = rd; dat0 = 0;
        start = 1; step(); start = 0;
    endtask

    // Wait for the stop command, hold busy, release, wait for completion
    task automatic finish_stop(input int stop0, input int bend0, input bit rnd, input string req);
        int lim = 0;
        while (n_stop == stop0 && lim < 3000) begin
            if (rnd) begin
                buf_full = ($urandom % 4) == 0;
                buf_empty = ($urandom % 4) == 0;
                card_vld = ($urandom % 4) != 0;
            end
            step(); lim++;
        end
        buf_full = 0; buf_empty = 0;
        chk(n_stop == stop0 + 1, req, n_stop - stop0, 1);
        repeat (3) step();
        chk(dat0_busy == 1'b1, "R9", dat0_busy, 1);
        dat0 = 1;
        lim = 0;
        while (!xfer_done && lim < 20) begin step(); lim++; end
        chk(n_bend == bend0 + 1, "R9", n_bend - bend0, 1);
        chk(xfer_done == 1'b1, "R9", xfer_done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0, p0, b0, n;
        void'($urandom(32'd2024));
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk(card_clk_en == 0 && buf_stb == 0 && stop_cmd == 0, "R1", card_clk_en, 0);
        chk(clk_off == 0 && xfer_done == 0 && rd_tmo == 0 && busy_end_irq == 0, "R1", xfer_done, 0);

        // R2 directed counted read
        card_vld = 1;
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(3, 1, 1);
        finish_stop(p0, b0, 0, "R2");
        chk(n_stb - s0 == exp_words(3), "R2", n_stb - s0, exp_words(3));

        // R2/R3 random gating, both directions
        for (int i = 0; i < 6; i++) begin
            n = 1 + ($urandom % 8);
            s0 = n_stb; p0 = n_stop; b0 = n_bend;
            kick(n, 1, i[0]);
            finish_stop(p0, b0, 1, "R2");
            chk(n_stb - s0 == exp_words(n), "R3", n_stb - s0, exp_words(n));
        end

        // R3 directed read gating and self-restart
        card_vld = 1;
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(2, 1, 1);
        buf_full = 1; step(); step();
        chk(card_clk_en == 0 && clk_off == 1 && buf_stb == 0, "R3", card_clk_en, 0);
        buf_full = 0; step();
        chk(card_clk_en == 1 && clk_off == 0, "R3", card_clk_en, 1);
        finish_stop(p0, b0, 0, "R3");
        chk(n_stb - s0 == exp_words(2), "R3", n_stb - s0, exp_words(2));

        // R3 directed write gating
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(1, 1, 0);
        buf_empty = 1; step(); step();
        chk(card_clk_en == 0 && clk_off == 1 && buf_stb == 0, "R3", buf_stb, 0);
        buf_empty = 0;
        finish_stop(p0, b0, 0, "R3");

        // R2 zero count means full range
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(0, 1, 0);
        finish_stop(p0, b0, 0, "R2");
        chk(n_stb - s0 == exp_words(0), "R2", n_stb - s0, exp_words(0));

        // R4 gap request mid-block, R5 continue
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(4, 1, 0);
        step();
        gap_req = 1; step(); gap_req = 0;
        repeat (10) step();
        chk(n_stb - s0 == BW, "R4", n_stb - s0, BW);
        chk(xfer_done == 1, "R4", xfer_done, 1);
        repeat (5) step();
        chk(n_stb - s0 == BW && card_clk_en == 0, "R4", n_stb - s0, BW);
        cont_req = 1; step(); cont_req = 0;
        chk(xfer_done == 0, "R5", xfer_done, 0);
        finish_stop(p0, b0, 0, "R5");
        chk(n_stb - s0 == exp_words(4), "R5", n_stb - s0, exp_words(4));

        // R6 infinite mode, R7 abort
        s0 = n_stb; p0 = n_stop; b0 = n_bend;
        kick(1, 0, 0);
        repeat (40) step();
        chk(n_stop == p0, "R6", n_stop - p0, 0);
        chk(n_stb - s0 >= 36, "R6", n_stb - s0, 36);
        s0 = n_stb;
        abort_req = 1; step(); abort_req = 0;
        finish_stop(p0, b0, 0, "R7");
        chk(n_stb == s0, "R7", n_stb - s0, 0);

        // R8 abort while the clock is gated
        card_vld = 1;
        p0 = n_stop; b0 = n_bend;
        kick(5, 1, 1);
        buf_full = 1; repeat (3) step();
        chk(clk_off == 1, "R8", clk_off, 1);
        s0 = n_stb;
        abort_req = 1; step(); abort_req = 0;
        chk(stop_cmd == 1 && card_clk_en == 1, "R8", card_clk_en, 1);
        finish_stop(p0, b0, 0, "R8");
        chk(n_stop_noclk == 0, "R8", n_stop_noclk, 0);

        // R10 read timeout and clear on next start
        card_vld = 0;
        p0 = n_stop; b0 = n_bend;
        kick(2, 1, 1);
        repeat (TMO - 4) step();
        chk(rd_tmo == 0, "R10", rd_tmo, 0);
        repeat (8) step();
        chk(rd_tmo == 1, "R10", rd_tmo, 1);
        abort_req = 1; step(); abort_req = 0;
        finish_stop(p0, b0, 0, "R10");
        chk(rd_tmo == 1, "R10", rd_tmo, 1);
        card_vld = 1;
        p0 = n_stop; b0 = n_bend;
        kick(1, 1, 1);
        chk(rd_tmo == 0, "R10", rd_tmo, 0);
        finish_stop(p0, b0, 0, "R10");

        // R9 live busy status across the whole run
        chk(n_busy_bad == 0, "R9", n_busy_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule